// File: doc/BRIEF.md
# Two-Wire Serial Link Assist Engine

This peripheral sits between a host CPU bus and a two-line open-drain serial link. It moves whole bytes, so the host does not have to toggle the wires itself. The host loads a byte into the transmit register once the engine reports that it can accept one. The host collects incoming bytes from the receive register once the received flag is up. Handshaking runs one bit at a time, and its timing comes from one of four timing-configuration registers. The current CPU speed-mode input picks which of the four is in use.

On the wire, each bit is sent by pulling one line low: line A carries a 0 and line B carries a 1. The receiver answers by pulling the other line low. The sender then releases its line, the receiver releases its own, and the sender waits a programmed number of ticks before it sends the next bit. Bytes go least significant bit first. If an answer or a release does not arrive within a bound, the engine flags an error, drops the transfer and lets go of both lines. Packet framing and higher protocol layers belong to the host software.

Top module: `link_assist`

## Requirements
- R1: After reset the status register (address 1) reads 0x20, the control register (address 0) reads 0x80, the timing registers at addresses 4, 5, 6 and 7 read 0x97, 0xB4, 0xB4 and 0xB4, and both line pulls are inactive.
- R2: The status word carries transmit-ready in bit 5, byte-received in bit 4, error in bit 6 and receive-busy in bit 3. All other bits read 0.
- R3: A write to the transmit register (address 3) is accepted only while bit 5 is set. It clears bit 5 and starts sending the byte. A write while bit 5 is clear is ignored. Bit 5 is set again once the byte has been sent.
- R4: A transmitted bit of value 0 pulls line A low and a bit of value 1 pulls line B low. The engine waits for the receiver to pull the other line low, releases its own line, and waits until both lines are high. Bits go out least significant first.
- R5: A received byte sets bit 4, and reading address 2 returns it. That read clears bit 4. A later byte overwrites an unread one, so the register always holds the most recent byte.
- R6: While a reception is under way and no byte is yet complete, bit 3 reads 1 and bit 4 reads 0. The engine answers each bit by pulling the line opposite the one the sender pulled.
- R7: A control write with bit 7 set puts the engine in the idle state. It aborts any transfer, releases both lines and leaves the status at exactly 0x20. While idle, link activity is ignored. A control write with bit 7 clear arms the engine.
- R8: The timing register at address 4+m applies while the speed-mode input equals m. All four are readable and writable.
- R9: A divisor field (timing bits 7:5) of 111 in the selected register halts the engine. No line moves and no pending byte starts. Work resumes when a running setting is selected.
- R10: One tick is 2^n clocks, where n is the divisor field. If an acknowledge or a release is still missing after (wait+1)*8 ticks, the engine sets bit 6, clears bit 5 and releases both lines. Here wait is timing bits 4:0. The same wait value sets the number of ticks between transmitted bits.
- R11: The engine never pulls both lines low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_rdata | output | 8 | Read data for bus_addr |
| speed_mode | input | 2 | Current CPU speed mode; selects a timing register |
| line_a_in | input | 1 | Sensed level of line A (1 = released) |
| line_b_in | input | 1 | Sensed level of line B (1 = released) |
| line_a_pull | output | 1 | 1 pulls line A low |
| line_b_pull | output | 1 | 1 pulls line B low |

## Verification
A corrupted handshake state shows up directly on the line pulls. The link partner then either decodes the wrong byte within that transfer or never sees the acknowledge it expects. In the second case the error bit rises within (wait+1)*8 ticks. A wrong status update is visible on the next status read. Reading the status after every transfer, after every clear and during halts catches flags that stick or fail to rise within a few cycles of the event that should move them.

// File: rtl/link_assist_pkg.sv
// Shared definitions for the link assist engine: engine states, the
// register address map and status bit positions.
package link_assist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_DRIVE,
        ST_TX_REL,
        ST_TX_GAP,
        ST_RX_WAIT,
        ST_RX_ACK,
        ST_RX_REL,
        ST_ERR
    } eng_state_t;

    localparam int          ADDR_W    = 3;
    localparam logic [2:0]  ADDR_CTRL = 3'd0;
    localparam logic [2:0]  ADDR_STAT = 3'd1;
    localparam logic [2:0]  ADDR_RXD  = 3'd2;
    localparam logic [2:0]  ADDR_TXD  = 3'd3;

    localparam int ST_BIT_BUSY = 3;
    localparam int ST_BIT_RX   = 4;
    localparam int ST_BIT_RDY  = 5;
    localparam int ST_BIT_ERR  = 6;

endpackage

// File: rtl/lk_sync.sv
// Multi-stage synchronizer for one asynchronous line level.
// Assumes the input is a slow level (handshake line); resets to RESET_VAL.
module lk_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // shift the line level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= {STAGES{RESET_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/lk_tick_gen.sv
// Timing tick generator: one tick every 2^div_sel clocks.
// The all-ones divisor code means "halted": no ticks, halted flag set.
module lk_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick,
    output logic             halted
);
    localparam int               CNT_W     = (1 << DIV_W) - 1;
    localparam logic [DIV_W-1:0] HALT_CODE = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign halted = (div_sel == HALT_CODE);
    assign limit  = (CNT_W'(1) << div_sel) - CNT_W'(1);
    assign tick   = !halted && (cnt >= limit);

    // prescaler counter, cleared on each tick and while halted
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (halted || tick) cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/lk_bit_engine.sv
// Bit-level handshake engine for both directions.
// Assumes synchronized line inputs (1 = released). A 0 bit is sent on line A
// and a 1 bit on line B; the receiver acknowledges on the opposite line.
// Timeouts are counted in ticks; abort returns the engine to idle.
module lk_bit_engine
    import link_assist_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WAIT_W   = 5,
    parameter int TO_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              halt,
    input  logic              tick,
    input  logic [WAIT_W-1:0] wait_ticks,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              tx_pend,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_take,
    output logic              tx_done,
    output logic              rx_done,
    output logic              err_evt,
    output logic              busy,
    output logic              pull_a,
    output logic              pull_b,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int               CNT_W    = WAIT_W + TO_SHIFT + 1;
    localparam int               BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    eng_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  to_limit;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;
    logic              rx_bit;
    logic              timeout, gap_done, any_low, both_high, cur_bit;

    assign to_limit  = (CNT_W'(wait_ticks) + CNT_W'(1)) << TO_SHIFT;
    assign timeout   = (cnt >= to_limit);
    assign gap_done  = (cnt >= CNT_W'(wait_ticks));
    assign any_low   = !line_a || !line_b;
    assign both_high = line_a && line_b;
    assign cur_bit   = shreg[0];

    // next-state decision; everything freezes while halted
    always_comb begin
        nxt = state;
        if (!halt) begin
            case (state)
                ST_IDLE:     if (tx_pend) nxt = ST_TX_DRIVE;
                             else if (any_low) nxt = ST_RX_WAIT;
                ST_TX_DRIVE: if (cur_bit ? !line_a : !line_b) nxt = ST_TX_REL;
                             else if (timeout) nxt = ST_ERR;
                ST_TX_REL:   if (both_high) nxt = ST_TX_GAP;
                             else if (timeout) nxt = ST_ERR;
                ST_TX_GAP:   if (gap_done) nxt = (bitcnt == LAST_BIT) ? ST_IDLE : ST_TX_DRIVE;
                ST_RX_WAIT:  if (any_low) nxt = ST_RX_ACK;
                             else if (timeout) nxt = ST_ERR;
                ST_RX_ACK:   if (rx_bit ? line_b : line_a) nxt = ST_RX_REL;
                             else if (timeout) nxt = ST_ERR;
                ST_RX_REL:   if (both_high) nxt = (bitcnt == LAST_BIT) ? ST_IDLE : ST_RX_WAIT;
                             else if (timeout) nxt = ST_ERR;
                default:     nxt = state;
            endcase
        end
    end

    // state, tick counter, shift register and bit counter updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            bitcnt <= '0;
            rx_bit <= 1'b0;
        end else if (abort) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == ST_IDLE || state == ST_ERR) cnt <= '0;
            else if (tick) cnt <= cnt + CNT_W'(1);
            if (state == ST_IDLE && nxt == ST_TX_DRIVE) begin
                shreg  <= tx_byte;
                bitcnt <= '0;
            end
            if (state == ST_TX_GAP && nxt == ST_TX_DRIVE) begin
                shreg  <= shreg >> 1;
                bitcnt <= bitcnt + BIT_W'(1);
            end
            if (state == ST_IDLE && nxt == ST_RX_WAIT) bitcnt <= '0;
            if (state == ST_RX_WAIT && nxt == ST_RX_ACK) rx_bit <= !line_b;
            if (state == ST_RX_ACK && nxt == ST_RX_REL) shreg <= {rx_bit, shreg[DATA_W-1:1]};
            if (state == ST_RX_REL && nxt == ST_RX_WAIT) bitcnt <= bitcnt + BIT_W'(1);
        end
    end

    // event pulses and line drive decode
    assign tx_take = (state == ST_IDLE) && (nxt == ST_TX_DRIVE) && !abort;
    assign tx_done = (state == ST_TX_GAP) && (nxt == ST_IDLE) && !abort;
    assign rx_done = (state == ST_RX_REL) && (nxt == ST_IDLE) && !abort;
    assign err_evt = (state != ST_ERR) && (nxt == ST_ERR) && !abort;
    assign busy    = (state == ST_RX_WAIT) || (state == ST_RX_ACK) || (state == ST_RX_REL);
    assign rx_byte = shreg;
    assign pull_a  = ((state == ST_TX_DRIVE) && !cur_bit) || ((state == ST_RX_ACK) && rx_bit);
    assign pull_b  = ((state == ST_TX_DRIVE) && cur_bit)  || ((state == ST_RX_ACK) && !rx_bit);
endmodule

// File: rtl/lk_host_regs.sv
// Host register file: control latch, status flags, receive and transmit
// data, and one timing register per speed mode. Reads are combinational;
// read side effects and writes take effect at the clock edge.
module lk_host_regs
    import link_assist_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         N_MODES   = 4,
    parameter logic [7:0] CFG_RST_0 = 8'h97,
    parameter logic [7:0] CFG_RST_N = 8'hB4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       rd,
    input  logic [$clog2(N_MODES)-1:0] speed,
    input  logic                       tx_take,
    input  logic                       tx_done,
    input  logic                       rx_done,
    input  logic [DATA_W-1:0]          rx_byte,
    input  logic                       err_evt,
    input  logic                       busy,
    output logic [DATA_W-1:0]          rdata,
    output logic [DATA_W-1:0]          status,
    output logic [DATA_W-1:0]          cfg_sel,
    output logic                       idle,
    output logic                       tx_pend,
    output logic [DATA_W-1:0]          tx_byte
);
    localparam int MODE_W = $clog2(N_MODES);

    logic [DATA_W-1:0] cfg_q [N_MODES];
    logic [DATA_W-1:0] rx_q;
    logic              rdy, rxf, err;
    logic              clr_wr, tx_wr;

    assign clr_wr  = wr && (addr == ADDR_CTRL) && wdata[DATA_W-1];
    assign tx_wr   = wr && (addr == ADDR_TXD) && rdy;
    assign cfg_sel = cfg_q[speed];

    // assemble the status word from the individual flags
    always_comb begin
        status              = '0;
        status[ST_BIT_ERR]  = err;
        status[ST_BIT_RDY]  = rdy;
        status[ST_BIT_RX]   = rxf;
        status[ST_BIT_BUSY] = busy;
    end

    // read multiplexer
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {idle, {(DATA_W-1){1'b0}}};
            ADDR_STAT: rdata = status;
            ADDR_RXD:  rdata = rx_q;
            ADDR_TXD:  rdata = '0;
            default:   rdata = cfg_q[addr[MODE_W-1:0]];
        endcase
    end

    // timing registers, one per speed mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < N_MODES; m++) cfg_q[m] <= (m == 0) ? CFG_RST_0 : CFG_RST_N;
        end else if (wr && addr[ADDR_W-1]) begin
            cfg_q[addr[MODE_W-1:0]] <= wdata;
        end
    end

    // control latch, transmit holding register and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle <= 1'b1; rdy <= 1'b1; rxf <= 1'b0; err <= 1'b0;
            tx_pend <= 1'b0; tx_byte <= '0; rx_q <= '0;
        end else begin
            if (wr && addr == ADDR_CTRL) idle <= wdata[DATA_W-1];
            if (clr_wr) begin
                rxf <= 1'b0; err <= 1'b0; rdy <= 1'b1; tx_pend <= 1'b0;
            end else begin
                if (err_evt) begin
                    err <= 1'b1; rdy <= 1'b0; tx_pend <= 1'b0;
                end else if (tx_wr) begin
                    tx_pend <= 1'b1; tx_byte <= wdata; rdy <= 1'b0;
                end else begin
                    if (tx_take) tx_pend <= 1'b0;
                    if (tx_done) rdy <= 1'b1;
                end
                if (rx_done) begin
                    rxf <= 1'b1; rx_q <= rx_byte;
                end else if (rd && addr == ADDR_RXD) begin
                    rxf <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/link_assist.sv
// Two-wire link assist engine top: host registers, line synchronizers,
// tick generator and the bit handshake engine.
// Assumes the link lines are open-drain with external pull-ups; the pull
// outputs request a low level and the *_in inputs sense the wire.
module link_assist
    import link_assist_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int N_MODES     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TO_SHIFT    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [$clog2(N_MODES)-1:0] speed_mode,
    input  logic                       line_a_in,
    input  logic                       line_b_in,
    output logic                       line_a_pull,
    output logic                       line_b_pull
);
    localparam int DIV_W  = 3;
    localparam int WAIT_W = DATA_W - DIV_W;
    localparam int N_LINE = 2;

    logic [DATA_W-1:0] status_w, cfg_sel_w, tx_byte_w, rx_byte_w;
    logic              idle_w, tx_pend_w, tx_take_w, tx_done_w, rx_done_w;
    logic              err_evt_w, busy_w, tick_w, halt_w;
    logic [N_LINE-1:0] line_raw, line_s;

    assign line_raw = {line_b_in, line_a_in};

    for (genvar i = 0; i < N_LINE; i++) begin : g_sync
        lk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(line_raw[i]), .q(line_s[i])
        );
    end

    lk_host_regs #(.DATA_W(DATA_W), .N_MODES(N_MODES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .rd(bus_rd), .speed(speed_mode), .tx_take(tx_take_w), .tx_done(tx_done_w),
        .rx_done(rx_done_w), .rx_byte(rx_byte_w), .err_evt(err_evt_w), .busy(busy_w),
        .rdata(bus_rdata), .status(status_w), .cfg_sel(cfg_sel_w), .idle(idle_w),
        .tx_pend(tx_pend_w), .tx_byte(tx_byte_w)
    );

    lk_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_sel(cfg_sel_w[DATA_W-1 -: DIV_W]),
        .tick(tick_w), .halted(halt_w)
    );

    lk_bit_engine #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .TO_SHIFT(TO_SHIFT)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(idle_w), .halt(halt_w), .tick(tick_w),
        .wait_ticks(cfg_sel_w[WAIT_W-1:0]), .line_a(line_s[0]), .line_b(line_s[1]),
        .tx_pend(tx_pend_w), .tx_byte(tx_byte_w), .tx_take(tx_take_w),
        .tx_done(tx_done_w), .rx_done(rx_done_w), .err_evt(err_evt_w), .busy(busy_w),
        .pull_a(line_a_pull), .pull_b(line_b_pull), .rx_byte(rx_byte_w)
    );
endmodule

// File: rtl/link_assist_checker.sv
// Protocol and status checks for the link assist engine, bound to the top.
module link_assist_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       bus_rd,
    input logic [7:0] status,
    input logic       idle,
    input logic       halt,
    input logic       rx_done,
    input logic       pull_a,
    input logic       pull_b
);
    // R11: never both lines pulled low
    p_one_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_a && pull_b));

    // R3: accepted transmit write drops transmit-ready
    p_tx_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3 && status[5]) |=> !status[5]);

    // R10: error state keeps both lines released
    p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (!pull_a && !pull_b));

    // R7: clear write leaves only transmit-ready among the flags
    p_clear_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[7]) |=> ((status & 8'hF7) == 8'h20));

    // R7: a settled idle state drives no line
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> (!pull_a && !pull_b));

    // R9: halted engine holds its line drive
    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !bus_wr) |=> $stable({pull_a, pull_b}));

    // R5: reading received data clears the received flag
    p_rx_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2 && !rx_done) |=> !status[4]);
endmodule

bind link_assist link_assist_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .status(status_w), .idle(idle_w),
    .halt(halt_w), .rx_done(rx_done_w), .pull_a(line_a_pull), .pull_b(line_b_pull)
);

// File: tb/link_assist_test.sv
// Bench for link_assist: a behavioral link partner plus host bus tasks.
module link_assist_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    wire  [7:0] rdata;
    logic [1:0] speed = '0;
    logic       tb_a = 1'b0, tb_b = 1'b0;
    wire        pull_a, pull_b;
    wire        line_a = ~(pull_a | tb_a);
    wire        line_b = ~(pull_b | tb_b);
    int         checks = 0, fails = 0;
    logic [7:0] got, st, b;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_assist uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rdata), .speed_mode(speed), .line_a_in(line_a),
        .line_b_in(line_b), .line_a_pull(pull_a), .line_b_pull(pull_b)
    );

    function automatic logic [7:0] exp_status(input logic e, input logic r,
                                              input logic x, input logic bsy);
        return {1'b0, e, r, x, bsy, 3'b000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_high;
        do @(negedge clk); while (!(line_a && line_b));
    endtask

    // partner acting as receiver of one byte
    task automatic partner_rx(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            logic bv;
            do @(negedge clk); while (line_a && line_b);
            bv = !line_b;
            if (bv) tb_a = 1'b1; else tb_b = 1'b1;
            do @(negedge clk); while (bv ? !line_b : !line_a);
            tb_a = 1'b0; tb_b = 1'b0;
            wait_high();
            v[i] = bv;
        end
    endtask

    // partner acting as sender of one bit
    task automatic partner_tx_bit(input logic bv);
        wait_high();
        repeat (3) @(negedge clk);
        if (bv) tb_b = 1'b1; else tb_a = 1'b1;
        do @(negedge clk); while (bv ? line_a : line_b);
        tb_a = 1'b0; tb_b = 1'b0;
        wait_high();
    endtask

    task automatic partner_tx(input logic [7:0] v);
        for (int i = 0; i < 8; i++) partner_tx_bit(v[i]);
    endtask

    task automatic wait_ready;
        logic [7:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd_reg(3'd1, s);
            if (s[5]) return;
        end
        chk("R3 ready never returned", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd1, st); chk("R1 status", st, 8'h20);
        rd_reg(3'd0, st); chk("R1 ctrl", st, 8'h80);
        rd_reg(3'd4, st); chk("R1 cfg0", st, 8'h97);
        for (int m = 5; m < 8; m++) begin
            rd_reg(3'(m), st); chk("R1 cfgN", st, 8'hB4);
        end
        chk("R1 lines", {pull_a, pull_b}, 0);

        // R7 idle ignores link activity
        tb_a = 1'b1; repeat (20) @(negedge clk);
        chk("R7 no ack while idle", pull_b, 0);
        rd_reg(3'd1, st); chk("R7 idle status", st, 8'h20);
        tb_a = 1'b0; wait_high();
        wr_reg(3'd0, 8'h00);

        // R4 directed transmit with fast timing
        wr_reg(3'd4, 8'h02);
        wr_reg(3'd3, 8'hB1);
        partner_rx(got); chk("R4 tx byte", got, 8'hB1);
        wait_ready();
        rd_reg(3'd1, st); chk("R2 status after tx", st, exp_status(0, 1, 0, 0));

        // R6 busy alone during reception, then R5 reception
        b = 8'hC6;
        wait_high();
        tb_a = 1'b1; repeat (6) @(negedge clk);
        rd_reg(3'd1, st); chk("R6 busy", st, exp_status(0, 1, 0, 1));
        chk("R6 ack on line B", pull_b, 1);
        do @(negedge clk); while (line_b);
        tb_a = 1'b0; wait_high();
        for (int i = 1; i < 8; i++) partner_tx_bit(b[i]);
        repeat (8) @(negedge clk);
        rd_reg(3'd1, st); chk("R5 received flag", st, exp_status(0, 1, 1, 0));
        rd_reg(3'd2, got); chk("R5 rx byte", got, 8'hC6);
        rd_reg(3'd1, st); chk("R5 read clears", st, exp_status(0, 1, 0, 0));

        // R5 newer byte overwrites unread byte
        partner_tx(8'h01); partner_tx(8'hFE);
        repeat (8) @(negedge clk);
        rd_reg(3'd2, got); chk("R5 most recent", got, 8'hFE);
        rd_reg(3'd1, st); chk("R5 flag after read", st, 8'h20);

        // R10 timeout on missing acknowledge (limit 16 ticks of 1 clock)
        wr_reg(3'd4, 8'h01);
        wr_reg(3'd3, 8'hA5);
        repeat (6) @(negedge clk);
        rd_reg(3'd1, st); chk("R10 no early error", st, 8'h00);
        repeat (60) @(negedge clk);
        rd_reg(3'd1, st); chk("R10 error set", st, exp_status(1, 0, 0, 0));
        chk("R10 lines released", {pull_a, pull_b}, 0);
        wr_reg(3'd3, 8'h33);
        repeat (10) @(negedge clk);
        chk("R3 write ignored in error", {pull_a, pull_b}, 0);
        wr_reg(3'd0, 8'h80);
        rd_reg(3'd1, st); chk("R7 clear after error", st, 8'h20);
        wr_reg(3'd0, 8'h00);

        // R9 halt via mode 1, R8 mode select, R3 ignored write
        wr_reg(3'd5, 8'hE0);
        rd_reg(3'd5, st); chk("R8 cfg1 readback", st, 8'hE0);
        speed = 2'd1;
        wr_reg(3'd3, 8'h5A);
        repeat (40) @(negedge clk);
        chk("R9 lines idle while halted", {pull_a, pull_b}, 0);
        rd_reg(3'd1, st); chk("R9 not ready while pending", st, 8'h00);
        wr_reg(3'd3, 8'h11);
        speed = 2'd0;
        partner_rx(got); chk("R3 ignored write kept first byte", got, 8'h5A);
        wait_ready();
        wr_reg(3'd6, 8'h3C);
        rd_reg(3'd6, st); chk("R8 cfg2 readback", st, 8'h3C);

        // R4 / R5 random traffic under random timing settings
        for (int it = 0; it < 16; it++) begin
            logic [7:0] cfg;
            cfg = {3'($urandom % 3), 5'($urandom % 8)};
            wr_reg(3'd4, cfg);
            b = 8'($urandom);
            if ($urandom % 2 == 1) begin
                wr_reg(3'd3, b);
                partner_rx(got); chk("R4 random tx", got, b);
                wait_ready();
            end else begin
                partner_tx(b);
                repeat (8) @(negedge clk);
                rd_reg(3'd1, st); chk("R5 random rx flag", st, exp_status(0, 1, 1, 0));
                rd_reg(3'd2, got); chk("R5 random rx byte", got, b);
            end
        end

        report();
    end
endmodule